// File: doc/BRIEF.md
# Configuration-Space Window onto BAR Register Regions

This block gives a host a path into device register regions that are normally reached through base address registers, using nothing but configuration-space cycles. The host first programs three writable fields of a vendor capability structure: which BAR region to target, how many bytes to move (1, 2 or 4), and the byte offset inside that region. It then touches the 4-byte data field of the same structure. A write to that field turns into a write on an internal request/acknowledge bus. A read of that field turns into a read on the same bus, and the bytes that come back are returned to the host.

The configuration port completes one access at a time. It raises `cfg_ready` for a single cycle when the access is done. For an access that reaches the backend, the ready pulse waits for the backend acknowledge, so the host always sees the value just fetched. The backend bus is 32 bits wide and dword addressed. The block converts the programmed byte offset into a dword address and lane strobes, and it moves data between the low bytes of the data field and the matching lanes of the bus.

Top module: `cfgwin_top`

## Requirements
- R1: After reset, the BAR index, offset, length and data fields read as zero, `cfg_ready` is low and `bk_req` is low.
- R2: Word 0 reads `{8'h05, 8'd20, NEXT_PTR, 8'h09}` and the upper three bytes of word 1 read `{8'h00, 8'h00, INST_ID}`. Host writes to these bytes have no effect. Words 5 to 7 read zero.
- R3: The BAR index (word 1 byte 0), offset (word 2), length (word 3) and data (word 4) fields take host writes, each byte only where its byte enable is set.
- R4: A valid data-field write issues exactly one backend write. It carries `bk_bar` equal to the BAR index, `bk_addr` equal to the offset with bits 1:0 cleared, and `bk_be` covering length bytes starting at lane offset[1:0]. `bk_wdata` holds the low length bytes of the data field shifted up by 8*offset[1:0], with zero in every lane that is not strobed.
- R5: A valid data-field read issues exactly one backend read. The host receives the strobed lanes moved down to the low bytes, with zero above length bytes. The data field keeps that packed value.
- R6: For a backend access, `cfg_ready` stays low until `bk_ack`. The returned data is the `bk_rdata` sampled with that acknowledge.
- R7: A data access with a BAR index of 6 or more issues no backend transaction, and a read then returns zero.
- R8: A data access with a length value other than 1, 2 or 4 issues no backend transaction, and a read then returns zero.
- R9: A data access whose offset is not a multiple of the length issues no backend transaction, and a read then returns zero.
- R10: An access that issues no backend transaction completes with a one-cycle `cfg_ready` pulse in the cycle after it is presented. Every `cfg_ready` lasts one cycle.
- R11: `bk_req` stays high with stable `bk_bar`, `bk_addr`, `bk_be` and `bk_we` until `bk_ack`, and drops in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Host write request, held until `cfg_ready` |
| cfg_rd | input | 1 | Host read request, held until `cfg_ready` |
| cfg_addr | input | 3 | Dword index inside the capability structure |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data, little-endian |
| cfg_rdata | output | 32 | Read data, valid while `cfg_ready` is high |
| cfg_ready | output | 1 | One-cycle completion pulse |
| bk_req | output | 1 | Backend request, held until acknowledged |
| bk_we | output | 1 | Backend direction, 1 for write |
| bk_bar | output | 3 | Target BAR region |
| bk_addr | output | 32 | Dword-aligned byte address inside the region |
| bk_be | output | 4 | Backend lane strobes |
| bk_wdata | output | 32 | Backend write data, lane aligned |
| bk_ack | input | 1 | Backend acknowledge |
| bk_rdata | input | 32 | Backend read data, sampled with `bk_ack` |

## Verification
The hardest point to reach is the mix of lane position, access size and BAR index that separates a correctly steered access from a rejected one. Misalignment only shows for some pairs of offset[1:0] and length, and an out-of-range index or odd length must silence the backend completely. The stimulus sweeps every BAR index 0 to 7, seven length values including ones with stray upper bits, and all four low offset bits, issuing a data write and a data read for each. The backend model varies its acknowledge delay and stamps each response with a serial number, so a stale return cannot pass.

// File: rtl/cfgwin_pkg.sv
// Package: constants, word indices and types shared by the window logic.
// Assumes a 32-bit configuration data path and a 32-bit backend bus.
package cfgwin_pkg;

    localparam int          DW          = 32;
    localparam int          LANES       = DW / 8;
    localparam int          WORD_AW     = 3;
    localparam logic [7:0]  VNDR_CAP_ID = 8'h09;
    localparam logic [7:0]  WIN_TYPE    = 8'h05;
    localparam logic [7:0]  CAP_BYTES   = 8'd20;

    typedef enum logic [WORD_AW-1:0] {
        W_HEAD = 3'd0,
        W_SEL  = 3'd1,
        W_OFFS = 3'd2,
        W_SIZE = 3'd3,
        W_DATA = 3'd4
    } word_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic [7:0]    bar;
        logic [DW-1:0] offs;
        logic [DW-1:0] size;
        logic [DW-1:0] data;
    } win_regs_t;

    // Replace the bytes of old_v whose enable bit is set.
    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                  input logic [DW-1:0] new_v,
                                                  input logic [LANES-1:0] be);
        logic [DW-1:0] r;
        r = old_v;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgwin_regs.sv
// Module: cfgwin_regs
// Holds the host-writable window fields and muxes the capability words
// for reads. Read-only header bytes come from parameters.
// Assumes wr_en and ld_en never assert in the same cycle.
module cfgwin_regs
    import cfgwin_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter logic [7:0] INST_ID  = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] wr_word,
    input  logic [LANES-1:0]   wr_be,
    input  logic [DW-1:0]      wr_data,
    input  logic               ld_en,
    input  logic [DW-1:0]      ld_data,
    input  logic [WORD_AW-1:0] rd_word,
    output win_regs_t          regs,
    output logic [DW-1:0]      hdr_rdata
);

    win_regs_t regs_q;

    // Update writable fields from host writes or from a completed backend read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            if (wr_en) begin
                case (wr_word)
                    W_SEL:   if (wr_be[0]) regs_q.bar <= wr_data[7:0];
                    W_OFFS:  regs_q.offs <= merge_bytes(regs_q.offs, wr_data, wr_be);
                    W_SIZE:  regs_q.size <= merge_bytes(regs_q.size, wr_data, wr_be);
                    W_DATA:  regs_q.data <= merge_bytes(regs_q.data, wr_data, wr_be);
                    default: ;
                endcase
            end
            if (ld_en) regs_q.data <= ld_data;
        end
    end

    // Select the capability word addressed by the host.
    always_comb begin
        case (rd_word)
            W_HEAD:  hdr_rdata = {WIN_TYPE, CAP_BYTES, NEXT_PTR, VNDR_CAP_ID};
            W_SEL:   hdr_rdata = {16'h0000, INST_ID, regs_q.bar};
            W_OFFS:  hdr_rdata = regs_q.offs;
            W_SIZE:  hdr_rdata = regs_q.size;
            W_DATA:  hdr_rdata = regs_q.data;
            default: hdr_rdata = '0;
        endcase
    end

    assign regs = regs_q;

endmodule

// File: rtl/cfgwin_lanes.sv
// Module: cfgwin_lanes
// Decodes size and alignment, qualifies the BAR index, and steers bytes
// between the low bytes of the data field and the backend lanes.
// Purely combinational; assumes a 4-lane backend bus.
module cfgwin_lanes
    import cfgwin_pkg::*;
#(
    parameter int NUM_BARS = 6,
    parameter int BAR_W    = 3
) (
    input  win_regs_t          regs,
    input  logic [DW-1:0]      bk_rdata,
    output logic               win_ok,
    output logic [BAR_W-1:0]   bk_bar,
    output logic [DW-1:0]      bk_addr,
    output logic [LANES-1:0]   bk_be,
    output logic [DW-1:0]      bk_wdata,
    output logic [DW-1:0]      packed_rdata
);

    logic       sz1, sz2, sz4;
    logic       bar_ok, align_ok;
    logic [1:0] sh;
    logic [2:0] nbytes;

    // Decode the access size, the lane shift and the validity of the request.
    always_comb begin
        sz1      = (regs.size == 32'd1);
        sz2      = (regs.size == 32'd2);
        sz4      = (regs.size == 32'd4);
        sh       = regs.offs[1:0];
        nbytes   = sz4 ? 3'd4 : (sz2 ? 3'd2 : (sz1 ? 3'd1 : 3'd0));
        bar_ok   = ({24'h0, regs.bar} < NUM_BARS);
        align_ok = sz1 | (sz2 & ~regs.offs[0]) | (sz4 & (regs.offs[1:0] == 2'b00));
        win_ok   = bar_ok & align_ok;
    end

    // Form the dword address, lane strobes and BAR select for the backend.
    always_comb begin
        bk_addr = {regs.offs[DW-1:2], 2'b00};
        bk_bar  = regs.bar[BAR_W-1:0];
        if (sz4)      bk_be = 4'b1111;
        else if (sz2) bk_be = 4'b0011 << sh;
        else if (sz1) bk_be = 4'b0001 << sh;
        else          bk_be = 4'b0000;
    end

    // Per-lane steering: write bytes move up by sh, read bytes move down by sh.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [1:0] wr_src;
        logic [1:0] rd_src;
        assign wr_src = 2'(g) - sh;
        assign rd_src = 2'(g) + sh;
        assign bk_wdata[8*g +: 8]     = bk_be[g] ? regs.data[8*wr_src +: 8] : 8'h00;
        assign packed_rdata[8*g +: 8] = (3'(g) < nbytes) ? bk_rdata[8*rd_src +: 8] : 8'h00;
    end

endmodule

// File: rtl/cfgwin_ctrl.sv
// Module: cfgwin_ctrl
// Sequences host accesses: header and rejected accesses complete in one
// cycle; a qualified data access holds the host until the backend acks.
// Assumes the host holds cfg_wr/cfg_rd until it sees cfg_ready.
module cfgwin_ctrl
    import cfgwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_rd,
    input  logic [WORD_AW-1:0] cfg_addr,
    input  logic               win_ok,
    input  logic               bk_ack,
    input  logic [DW-1:0]      hdr_rdata,
    input  logic [DW-1:0]      packed_rdata,
    output logic               cfg_ready,
    output logic [DW-1:0]      cfg_rdata,
    output logic               bk_req,
    output logic               bk_we,
    output logic               reg_wr_en,
    output logic               ld_en
);

    state_e        state_q;
    logic          we_q;
    logic [DW-1:0] rdata_q;
    logic          accept, launch, data_hit;

    // Classify the access presented in the idle state.
    always_comb begin
        accept    = (state_q == ST_IDLE) && (cfg_wr || cfg_rd);
        data_hit  = (cfg_addr == W_DATA);
        launch    = accept && data_hit && win_ok;
        reg_wr_en = accept && cfg_wr;
        ld_en     = (state_q == ST_BUSY) && bk_ack && !we_q;
    end

    // Advance the access state machine and capture response data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q <= ST_BUSY;
                        we_q    <= cfg_wr;
                        rdata_q <= '0;
                    end else if (accept) begin
                        state_q <= ST_RESP;
                        rdata_q <= (!cfg_wr && !data_hit) ? hdr_rdata : '0;
                    end
                end
                ST_BUSY: begin
                    if (bk_ack) begin
                        state_q <= ST_RESP;
                        if (!we_q) rdata_q <= packed_rdata;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_ready = (state_q == ST_RESP);
    assign cfg_rdata = rdata_q;
    assign bk_req    = (state_q == ST_BUSY);
    assign bk_we     = we_q;

endmodule

// File: rtl/cfgwin_top.sv
// Module: cfgwin_top
// Configuration-space window that forwards sized accesses to BAR regions.
// Assumes one host access at a time and a backend that eventually acks.
module cfgwin_top
    import cfgwin_pkg::*;
#(
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter logic [7:0] INST_ID  = 8'h00,
    parameter int         NUM_BARS = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic         cfg_rd,
    input  logic [2:0]   cfg_addr,
    input  logic [3:0]   cfg_be,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  cfg_rdata,
    output logic         cfg_ready,
    output logic         bk_req,
    output logic         bk_we,
    output logic [2:0]   bk_bar,
    output logic [31:0]  bk_addr,
    output logic [3:0]   bk_be,
    output logic [31:0]  bk_wdata,
    input  logic         bk_ack,
    input  logic [31:0]  bk_rdata
);

    localparam int BAR_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1;

    win_regs_t     regs;
    logic [DW-1:0] hdr_rdata;
    logic [DW-1:0] packed_rdata;
    logic          win_ok;
    logic          reg_wr_en;
    logic          ld_en;
    logic [BAR_W-1:0] bar_sel;

    cfgwin_regs #(
        .NEXT_PTR (NEXT_PTR),
        .INST_ID  (INST_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_word   (cfg_addr),
        .wr_be     (cfg_be),
        .wr_data   (cfg_wdata),
        .ld_en     (ld_en),
        .ld_data   (packed_rdata),
        .rd_word   (cfg_addr),
        .regs      (regs),
        .hdr_rdata (hdr_rdata)
    );

    cfgwin_lanes #(
        .NUM_BARS (NUM_BARS),
        .BAR_W    (BAR_W)
    ) u_lanes (
        .regs         (regs),
        .bk_rdata     (bk_rdata),
        .win_ok       (win_ok),
        .bk_bar       (bar_sel),
        .bk_addr      (bk_addr),
        .bk_be        (bk_be),
        .bk_wdata     (bk_wdata),
        .packed_rdata (packed_rdata)
    );

    cfgwin_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_rd       (cfg_rd),
        .cfg_addr     (cfg_addr),
        .win_ok       (win_ok),
        .bk_ack       (bk_ack),
        .hdr_rdata    (hdr_rdata),
        .packed_rdata (packed_rdata),
        .cfg_ready    (cfg_ready),
        .cfg_rdata    (cfg_rdata),
        .bk_req       (bk_req),
        .bk_we        (bk_we),
        .reg_wr_en    (reg_wr_en),
        .ld_en        (ld_en)
    );

    assign bk_bar = 3'(bar_sel);

endmodule

// File: rtl/cfgwin_chk.sv
// Module: cfgwin_chk
// Protocol checker for cfgwin_top, attached by bind below.
// Assumes the environment follows the request/acknowledge rules.
module cfgwin_chk #(
    parameter int NUM_BARS = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_ready,
    input logic        bk_req,
    input logic        bk_we,
    input logic        bk_ack,
    input logic [2:0]  bk_bar,
    input logic [31:0] bk_addr,
    input logic [3:0]  bk_be,
    input logic [31:0] bk_wdata
);

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req && !bk_ack |=> bk_req);

    a_r11_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req && !bk_ack |=> $stable(bk_addr) && $stable(bk_be)
                              && $stable(bk_bar) && $stable(bk_we));

    a_r11_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req && bk_ack |=> !bk_req);

    a_r6_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req |-> !cfg_ready);

    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> !cfg_ready);

    a_r4_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req |-> (($countones(bk_be) == 1) || ($countones(bk_be) == 2)
                    || ($countones(bk_be) == 4)) && (bk_addr[1:0] == 2'b00));

    a_r7_bar_range: assert property (@(posedge clk) disable iff (!rst_n)
        bk_req |-> (32'(bk_bar) < NUM_BARS));

    for (genvar g = 0; g < 4; g++) begin : g_zl
        a_r4_unstrobed_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bk_req && bk_we && !bk_be[g] |-> (bk_wdata[8*g +: 8] == 8'h00));
    end

endmodule

bind cfgwin_top cfgwin_chk #(.NUM_BARS(NUM_BARS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ready (cfg_ready),
    .bk_req    (bk_req),
    .bk_we     (bk_we),
    .bk_ack    (bk_ack),
    .bk_bar    (bk_bar),
    .bk_addr   (bk_addr),
    .bk_be     (bk_be),
    .bk_wdata  (bk_wdata)
);

// File: tb/cfgwin_top_tb.sv
// Bench: sweeps BAR index, length value and low offset bits through data
// writes and reads; a backend model with variable delay stamps responses.
module cfgwin_top_tb;

    localparam logic [7:0] NP  = 8'h40;
    localparam logic [7:0] IID = 8'h07;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_ready;
    logic        bk_req, bk_we;
    logic [2:0]  bk_bar;
    logic [31:0] bk_addr, bk_wdata;
    logic [3:0]  bk_be;
    logic        bk_ack = 1'b0;
    logic [31:0] bk_rdata = '0;

    int n_chk = 0, n_bad = 0;
    int txn_cnt = 0, wait_cnt = 0, bk_delay = 0;
    logic        l_we;
    logic [2:0]  l_bar;
    logic [31:0] l_addr, l_wd;
    logic [3:0]  l_be;

    always #10 clk = ~clk;

    cfgwin_top #(.NEXT_PTR(NP), .INST_ID(IID), .NUM_BARS(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_ready(cfg_ready), .bk_req(bk_req),
        .bk_we(bk_we), .bk_bar(bk_bar), .bk_addr(bk_addr), .bk_be(bk_be),
        .bk_wdata(bk_wdata), .bk_ack(bk_ack), .bk_rdata(bk_rdata));

    function automatic logic [31:0] pat(logic [2:0] b, logic [31:0] a, int s);
        return {5'b0, b, a[7:0], 8'(s), 8'h3C};
    endfunction

    function automatic logic [31:0] size_mask(logic [31:0] len);
        return (len == 1) ? 32'h0000_00FF : (len == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    // Backend model: acks after bk_delay cycles and records the transaction.
    always @(negedge clk) begin
        if (bk_ack) begin
            bk_ack   <= 1'b0;
            wait_cnt <= 0;
        end else if (bk_req) begin
            if (wait_cnt >= bk_delay) begin
                bk_ack   <= 1'b1;
                bk_rdata <= pat(bk_bar, bk_addr, txn_cnt);
                l_we <= bk_we; l_bar <= bk_bar; l_addr <= bk_addr;
                l_be <= bk_be; l_wd <= bk_wdata;
                txn_cnt <= txn_cnt + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit we, input logic [2:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = wd; cfg_wr = we; cfg_rd = !we;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cfg_ready);
        rd = cfg_rdata;
        cfg_wr = 1'b0; cfg_rd = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!cfg_ready && !bk_req, "R1 idle outputs", {cfg_ready, bk_req}, 0);
        xfer(0, 3'd1, 4'h0, 0, rd, cyc);
        check(rd == {16'h0, IID, 8'h00}, "R1 bar field", rd, {16'h0, IID, 8'h00});
        xfer(0, 3'd2, 4'h0, 0, rd, cyc);
        check(rd == 0, "R1 offset field", rd, 0);
        xfer(0, 3'd3, 4'h0, 0, rd, cyc);
        check(rd == 0, "R1 length field", rd, 0);
        check(cyc == 1, "R10 header latency", cyc, 1);

        // R2: read-only header bytes
        xfer(1, 3'd0, 4'hF, 32'hFFFF_FFFF, rd, cyc);
        xfer(0, 3'd0, 4'h0, 0, rd, cyc);
        check(rd == {8'h05, 8'd20, NP, 8'h09}, "R2 word0", rd, {8'h05, 8'd20, NP, 8'h09});
        xfer(1, 3'd1, 4'hF, 32'hFFFF_FF03, rd, cyc);
        xfer(0, 3'd1, 4'h0, 0, rd, cyc);
        check(rd == {16'h0, IID, 8'h03}, "R2 word1 RO bytes", rd, {16'h0, IID, 8'h03});
        for (int w = 5; w < 8; w++) begin
            xfer(1, 3'(w), 4'hF, 32'hDEAD_BEEF, rd, cyc);
            xfer(0, 3'(w), 4'h0, 0, rd, cyc);
            check(rd == 0, "R2 unused word", rd, 0);
        end

        // R3: byte-enable merging
        xfer(1, 3'd2, 4'hF, 32'h1122_3344, rd, cyc);
        xfer(1, 3'd2, 4'b0101, 32'hAABB_CCDD, rd, cyc);
        xfer(0, 3'd2, 4'h0, 0, rd, cyc);
        check(rd == 32'h11BB_33DD, "R3 offset merge", rd, 32'h11BB_33DD);
        xfer(1, 3'd4, 4'hF, 32'h0102_0304, rd, cyc);
        xfer(1, 3'd4, 4'b1000, 32'hF000_0000, rd, cyc);
        xfer(1, 3'd1, 4'h0, 32'h0000_0002, rd, cyc);
        xfer(0, 3'd1, 4'h0, 0, rd, cyc);
        check(rd[7:0] == 8'h03, "R3 bar no-enable", rd[7:0], 8'h03);

        // Sweep: BAR index x length value x low offset bits
        for (int b = 0; b < 8; b++) begin
            for (int li = 0; li < 7; li++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    logic [31:0] len, off, d, expd, mask;
                    logic [3:0]  ebe;
                    bit ok;
                    int t0;
                    case (li)
                        0: len = 0; 1: len = 1; 2: len = 2; 3: len = 3;
                        4: len = 4; 5: len = 8; default: len = 32'h0000_0102;
                    endcase
                    off = 32'h0001_2340 + 32'(lo) + 32'(b << 4);
                    d   = 32'hC0DE_0000 + 32'(b * 97 + li * 13 + lo);
                    ok  = (b < 6) && ((len == 1) || (len == 2 && !off[0])
                                      || (len == 4 && off[1:0] == 0));
                    mask = size_mask(len);
                    ebe  = (len == 4) ? 4'hF : (len == 2) ? 4'(3 << lo) : 4'(1 << lo);
                    bk_delay = (b + lo) % 4;
                    xfer(1, 3'd1, 4'h1, 32'(b), rd, cyc);
                    xfer(1, 3'd2, 4'hF, off, rd, cyc);
                    xfer(1, 3'd3, 4'hF, len, rd, cyc);
                    // data write
                    t0 = txn_cnt;
                    xfer(1, 3'd4, 4'hF, d, rd, cyc);
                    if (ok) begin
                        expd = (d & mask) << (8 * lo);
                        check(txn_cnt == t0 + 1, "R4 one write issued", txn_cnt - t0, 1);
                        check(l_we && l_bar == 3'(b) && l_addr == {off[31:2], 2'b00} && l_be == ebe,
                              "R4 write controls", {l_we, l_bar, l_be, l_addr},
                              {1'b1, 3'(b), ebe, off[31:2], 2'b00});
                        check(l_wd == expd, "R4 write lanes", l_wd, expd);
                        check(cyc == bk_delay + 2, "R6 write latency", cyc, bk_delay + 2);
                    end else begin
                        check(txn_cnt == t0, (b >= 6) ? "R7 no write" : (li == 0 || li == 3 || li >= 5)
                              ? "R8 no write" : "R9 no write", txn_cnt - t0, 0);
                        check(cyc == 1, "R10 rejected latency", cyc, 1);
                    end
                    // data read
                    t0 = txn_cnt;
                    xfer(0, 3'd4, 4'h0, 0, rd, cyc);
                    if (ok) begin
                        expd = (pat(3'(b), {off[31:2], 2'b00}, t0) >> (8 * lo)) & mask;
                        check(txn_cnt == t0 + 1 && !l_we, "R5 one read issued", txn_cnt - t0, 1);
                        check(rd == expd, "R5 R6 packed read data", rd, expd);
                        if (li == 2 && lo == 2) begin
                            // data field keeps packed value: replay it as a write
                            xfer(1, 3'd4, 4'h0, 32'hFFFF_FFFF, rd, cyc);
                            check(l_wd == (expd << 16), "R5 data field holds packed", l_wd, expd << 16);
                        end
                    end else begin
                        check(txn_cnt == t0 && rd == 0, (b >= 6) ? "R7 read zero"
                              : (li == 0 || li == 3 || li >= 5) ? "R8 read zero" : "R9 read zero",
                              {txn_cnt - t0, rd}, 0);
                    end
                end
            end
        end

        // R11 with a long backend stall
        bk_delay = 9;
        xfer(1, 3'd1, 4'h1, 32'd5, rd, cyc);
        xfer(1, 3'd2, 4'hF, 32'hFFFF_FFFC, rd, cyc);
        xfer(1, 3'd3, 4'hF, 32'd4, rd, cyc);
        xfer(0, 3'd4, 4'h0, 0, rd, cyc);
        check(cyc == 11, "R11 stall held", cyc, 11);
        check(rd == pat(3'd5, 32'hFFFF_FFFC, txn_cnt - 1), "R6 fresh data after stall",
              rd, pat(3'd5, 32'hFFFF_FFFC, txn_cnt - 1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule